// File: doc/BRIEF.md
# Pulse-Swallow Dual-Modulus Divider Control

This block turns a dual-modulus prescaler into a programmable divider whose overall ratio, from the high-frequency input to the comparison pulse, is P·N + A. The block runs on the prescaler input clock. It contains a digital model of the prescaler, so the loop can be exercised cycle by cycle. It also holds two down-counters. The swallow counter (A, 0 to 127) keeps the prescaler in its long modulus (P+1) for the first A prescaler output cycles. The program counter (N, 5 to 2047) counts every prescaler output cycle and ends the comparison period when it expires. A configuration bit picks P = 64 or P = 128.

The settings are written through a simple strobe. A write is held in a shadow register and replaces the running values only at the next comparison-period boundary. The current period therefore always completes with the values it started with. A standby input holds all counters in their reload state and keeps the outputs quiet. The first comparison period starts cleanly when standby is released. A < N is a precondition of correct use.

Top module: `pswallow_div`

## Requirements
- R1: Out of reset the running settings are A=0, N=5, P=64, and `fp`, `pre_out` and `mod_ext` are low. The first `fp` comes 320 clock edges after reset is released.
- R2: With A < N, consecutive `fp` pulses are spaced by exactly P·N + A clock edges.
- R3: `cfg_p64` = 1 selects P = 64 and `cfg_p64` = 0 selects P = 128.
- R4: In each comparison period, `mod_ext` is high during exactly the first A prescaler output cycles and low during the rest.
- R5: Each comparison period contains exactly N `pre_out` pulses.
- R6: A prescaler cycle lasts P+1 clocks when `mod_ext` is high and P clocks when it is low. `mod_ext` changes only at the edge that ends a prescaler cycle.
- R7: `fp` is high for exactly one clock per comparison period. It rises one edge after the clock edge that ends the period.
- R8: A written setting (sampled on a clock edge with `cfg_wr` = 1) takes effect at the first period boundary after that edge. A write sampled on the boundary edge itself waits for the following boundary.
- R9: While `standby` is high, `fp` and `pre_out` stay low, the counters are held at reload, and a pending write is applied. After release, the first `fp` comes P·N + A edges later, counting the first edge that samples `standby` low.
- R10: A = 0 gives a period of P·N with `mod_ext` never high. A = N−1 is divided correctly.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Prescaler input clock |
| rst_n | input | 1 | Synchronous active-low reset |
| standby | input | 1 | High holds the channel in power-save |
| cfg_wr | input | 1 | Write strobe for the settings |
| cfg_swallow | input | 7 | Swallow count A |
| cfg_prog | input | 11 | Program count N |
| cfg_p64 | input | 1 | 1: P=64, 0: P=128 |
| mod_ext | output | 1 | Modulus control, high selects P+1 |
| pre_out | output | 1 | One-clock pulse marking the last clock of each prescaler cycle |
| fp | output | 1 | Comparison pulse, one clock per period |

## Verification
The collision of concern is a settings write landing on the same clock edge as a period boundary, where the counters reload. The bench predicts the boundary edge from its own model of the running period and times a write so that `cfg_wr` is sampled on exactly that edge. The scoreboard then expects the old settings to start the next period and the new ones only one period later. A second overlap, a write sampled during standby, is judged by the length of the first period after release.

// File: rtl/psd_pkg.sv
// Package: shared constants and types for the pulse-swallow divider.
// Assumes: reset settings are legal (A < N, N >= 5).
package psd_pkg;
    localparam int SWL_W   = 7;   // swallow counter width
    localparam int PRG_W   = 11;  // program counter width
    localparam int PRE_LOG = 6;   // log2 of the short prescaler modulus
    localparam int RST_SWL = 0;
    localparam int RST_PRG = 5;
    localparam bit RST_P64 = 1'b1;

    // Prescaler modulus currently in use
    typedef enum logic {
        MOD_BASE  = 1'b0,
        MOD_PLUS1 = 1'b1
    } psd_mod_e;
endpackage

// File: rtl/psd_cfg_hold.sv
// Module: settings shadow. Holds a written setting until the next reload
// event, then makes it the running setting.
// Assumes: reload pulses at period boundaries and during standby.
module psd_cfg_hold #(
    parameter int SWL_W   = 7,
    parameter int PRG_W   = 11,
    parameter int RST_SWL = 0,
    parameter int RST_PRG = 5,
    parameter bit RST_P64 = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [SWL_W-1:0] wr_swl,
    input  logic [PRG_W-1:0] wr_prg,
    input  logic             wr_p64,
    input  logic             reload,
    output logic [SWL_W-1:0] nxt_swl,
    output logic [PRG_W-1:0] nxt_prg,
    output logic             nxt_p64,
    output logic             run_p64
);
    logic [SWL_W-1:0] run_swl, sh_swl;
    logic [PRG_W-1:0] run_prg, sh_prg;
    logic             sh_p64, pending;

    // Values loaded at the next reload: the shadow if a write waits
    always_comb begin
        nxt_swl = pending ? sh_swl : run_swl;
        nxt_prg = pending ? sh_prg : run_prg;
        nxt_p64 = pending ? sh_p64 : run_p64;
    end

    // Running and shadow registers; a write on a reload edge stays pending
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_swl <= SWL_W'(RST_SWL);
            run_prg <= PRG_W'(RST_PRG);
            run_p64 <= RST_P64;
            sh_swl  <= SWL_W'(RST_SWL);
            sh_prg  <= PRG_W'(RST_PRG);
            sh_p64  <= RST_P64;
            pending <= 1'b0;
        end else begin
            if (reload) begin
                run_swl <= nxt_swl;
                run_prg <= nxt_prg;
                run_p64 <= nxt_p64;
                pending <= 1'b0;
            end
            if (wr_en) begin
                sh_swl  <= wr_swl;
                sh_prg  <= wr_prg;
                sh_p64  <= wr_p64;
                pending <= 1'b1;
            end
        end
    end

    // R8: running settings only move on a reload event
    assert_run_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !reload |=> ($stable(run_swl) && $stable(run_prg) && $stable(run_p64)));
endmodule

// File: rtl/psd_prescaler.sv
// Module: digital model of the dual-modulus prescaler. Divides clk by P or
// P+1 and marks the last clock of each cycle on tick.
// Assumes: ext changes only at the edge where tick is high.
module psd_prescaler #(
    parameter int PRE_LOG = 6
) (
    input  logic clk,
    input  logic rst_n,
    input  logic hold,
    input  logic sel_p64,
    input  logic ext,
    output logic tick
);
    import psd_pkg::*;
    localparam int CNT_W = PRE_LOG + 2;
    localparam logic [CNT_W-1:0] P_SHORT = CNT_W'(1) << PRE_LOG;
    localparam logic [CNT_W-1:0] P_LONG  = P_SHORT << 1;

    logic [CNT_W-1:0] cnt, last;
    psd_mod_e         mode;

    // Terminal count of the cycle in progress
    always_comb begin
        mode = ext ? MOD_PLUS1 : MOD_BASE;
        last = (sel_p64 ? P_SHORT : P_LONG) - CNT_W'(1)
             + ((mode == MOD_PLUS1) ? CNT_W'(1) : CNT_W'(0));
    end

    assign tick = !hold && (cnt == last);

    // Cycle counter, cleared in standby and at each cycle end
    always_ff @(posedge clk) begin
        if (!rst_n || hold) cnt <= '0;
        else if (tick)      cnt <= '0;
        else                cnt <= cnt + CNT_W'(1);
    end

    // R6: the counter never runs past the long modulus
    assert_cycle_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= P_LONG);
endmodule

// File: rtl/psd_swallow_ctr.sv
// Module: swallow and program counters. Keeps the prescaler in P+1 while
// swallow cycles remain and flags the period end when N expires.
// Assumes: loaded values satisfy A < N and N >= 5.
module psd_swallow_ctr #(
    parameter int SWL_W   = 7,
    parameter int PRG_W   = 11,
    parameter int RST_SWL = 0,
    parameter int RST_PRG = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hold,
    input  logic             tick,
    input  logic [SWL_W-1:0] ld_swl,
    input  logic [PRG_W-1:0] ld_prg,
    output logic             ext,
    output logic             wrap
);
    logic [SWL_W-1:0] swl_rem;
    logic [PRG_W-1:0] prg_rem;

    assign ext  = (swl_rem != '0);
    assign wrap = tick && (prg_rem == PRG_W'(1));

    // Down-counters: reload in standby or at period end, else count ticks
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            swl_rem <= SWL_W'(RST_SWL);
            prg_rem <= PRG_W'(RST_PRG);
        end else if (hold || wrap) begin
            swl_rem <= ld_swl;
            prg_rem <= ld_prg;
        end else if (tick) begin
            prg_rem <= prg_rem - PRG_W'(1);
            if (swl_rem != '0) swl_rem <= swl_rem - SWL_W'(1);
        end
    end

    // R5: the program counter never reaches zero with legal settings
    assert_prg_live_R5: assert property (@(posedge clk) disable iff (!rst_n)
        prg_rem != '0);
    // R4: swallow count only drops on a prescaler cycle end
    assert_swl_on_tick_R4: assert property (@(posedge clk) disable iff (!rst_n || hold)
        (!tick && !wrap) |=> $stable(swl_rem));
endmodule

// File: rtl/pswallow_div.sv
// Module: top of the pulse-swallow divider. Ties the prescaler model, the
// counters and the settings shadow together and registers fp.
// Assumes: clk is the prescaler input; settings obey A < N.
module pswallow_div #(
    parameter int SWL_W   = psd_pkg::SWL_W,
    parameter int PRG_W   = psd_pkg::PRG_W,
    parameter int PRE_LOG = psd_pkg::PRE_LOG
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             standby,
    input  logic             cfg_wr,
    input  logic [SWL_W-1:0] cfg_swallow,
    input  logic [PRG_W-1:0] cfg_prog,
    input  logic             cfg_p64,
    output logic             mod_ext,
    output logic             pre_out,
    output logic             fp
);
    logic [SWL_W-1:0] nxt_swl;
    logic [PRG_W-1:0] nxt_prg;
    logic             nxt_p64, run_p64, wrap, reload;

    assign reload = wrap || standby;

    psd_cfg_hold #(
        .SWL_W(SWL_W), .PRG_W(PRG_W),
        .RST_SWL(psd_pkg::RST_SWL), .RST_PRG(psd_pkg::RST_PRG),
        .RST_P64(psd_pkg::RST_P64)
    ) u_cfg (
        .clk(clk), .rst_n(rst_n), .wr_en(cfg_wr),
        .wr_swl(cfg_swallow), .wr_prg(cfg_prog), .wr_p64(cfg_p64),
        .reload(reload), .nxt_swl(nxt_swl), .nxt_prg(nxt_prg),
        .nxt_p64(nxt_p64), .run_p64(run_p64)
    );

    psd_prescaler #(.PRE_LOG(PRE_LOG)) u_pre (
        .clk(clk), .rst_n(rst_n), .hold(standby),
        .sel_p64(run_p64), .ext(mod_ext), .tick(pre_out)
    );

    psd_swallow_ctr #(
        .SWL_W(SWL_W), .PRG_W(PRG_W),
        .RST_SWL(psd_pkg::RST_SWL), .RST_PRG(psd_pkg::RST_PRG)
    ) u_cnt (
        .clk(clk), .rst_n(rst_n), .hold(standby), .tick(pre_out),
        .ld_swl(nxt_swl), .ld_prg(nxt_prg), .ext(mod_ext), .wrap(wrap)
    );

    // Comparison pulse, one edge after the period-ending edge
    always_ff @(posedge clk) begin
        if (!rst_n) fp <= 1'b0;
        else        fp <= wrap;
    end

    // R7: fp is a single-clock pulse
    assert_fp_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
        fp |=> !fp);
    // R2: fp only follows a prescaler cycle end
    assert_fp_after_tick_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fp) |-> $past(pre_out));
    // R9: no comparison pulse after a standby edge
    assert_quiet_standby_R9: assert property (@(posedge clk) disable iff (!rst_n)
        standby |=> !fp);
    // R6: modulus control is steady inside a prescaler cycle
    assert_mod_steady_R6: assert property (@(posedge clk) disable iff (!rst_n || standby)
        !pre_out |=> $stable(mod_ext));
endmodule

// File: tb/pswallow_div_bench.sv
`timescale 1ns/1ps
module pswallow_div_bench;
    typedef struct packed {
        logic [6:0]  a;
        logic [10:0] n;
        logic        p64;
    } cfg_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        standby = 1'b0;
    logic        cfg_wr = 1'b0;
    logic [6:0]  cfg_swallow = '0;
    logic [10:0] cfg_prog = '0;
    logic        cfg_p64 = 1'b0;
    logic        mod_ext, pre_out, fp;

    int total = 0;
    int fails = 0;
    bit done = 0;
    cfg_t exp_q[$];

    always #4 clk = ~clk;

    pswallow_div u_pswallow_div (
        .clk(clk), .rst_n(rst_n), .standby(standby), .cfg_wr(cfg_wr),
        .cfg_swallow(cfg_swallow), .cfg_prog(cfg_prog), .cfg_p64(cfg_p64),
        .mod_ext(mod_ext), .pre_out(pre_out), .fp(fp)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Driver: writes a setting and pushes the expected item
    task automatic write_cfg(input int a, input int n, input bit p64);
        cfg_t c;
        c.a = 7'(a); c.n = 11'(n); c.p64 = p64;
        @(negedge clk);
        cfg_swallow = c.a; cfg_prog = c.n; cfg_p64 = c.p64; cfg_wr = 1'b1;
        exp_q.push_back(c);
        @(negedge clk);
        cfg_wr = 1'b0;
    endtask

    task automatic wait_fp(input int k);
        repeat (k) begin
            do begin @(posedge clk); #1; end while (!fp);
        end
    endtask

    // Monitor / scoreboard state
    cfg_t act_c, pend_c;
    bit   pend_v, tick_prev, fp_prev;
    int   clk_cnt, tick_cnt, swl_cnt, pcl, exp_len;

    function automatic int p_of(input cfg_t c);
        return c.p64 ? 64 : 128;
    endfunction

    always @(posedge clk) begin
        #1;
        if (!rst_n) begin
            act_c = '{a: 7'd0, n: 11'd5, p64: 1'b1};
            pend_v = 0; clk_cnt = 0; tick_cnt = 0; swl_cnt = 0;
            pcl = 0; tick_prev = 0; fp_prev = 0; exp_len = 0;
        end else if (standby) begin
            check(!fp && !pre_out, "R9 quiet in standby", {fp, pre_out}, 0);
            if (pend_v) begin act_c = pend_c; pend_v = 0; end
            clk_cnt = 0; tick_cnt = 0; swl_cnt = 0; pcl = 0;
            tick_prev = 0; fp_prev = 0;
            if (cfg_wr && exp_q.size() > 0) begin pend_c = exp_q.pop_front(); pend_v = 1; end
        end else begin
            clk_cnt++; pcl++;
            if (tick_prev) begin
                check(pcl == exp_len, "R6 prescaler cycle length", pcl, exp_len);
                pcl = 0;
            end
            if (fp) begin
                check(!fp_prev, "R7 fp width", 2, 1);
                check(clk_cnt == p_of(act_c) * act_c.n + act_c.a,
                      "R2 R3 R10 period", clk_cnt, p_of(act_c) * act_c.n + act_c.a);
                check(tick_cnt == act_c.n, "R5 prescaler pulses", tick_cnt, act_c.n);
                check(swl_cnt == act_c.a, "R4 swallow cycles", swl_cnt, act_c.a);
                clk_cnt = 0; tick_cnt = 0; swl_cnt = 0;
                if (pend_v) begin act_c = pend_c; pend_v = 0; end  // R8
            end
            if (pre_out) begin
                tick_cnt++;
                if (mod_ext) swl_cnt++;
                exp_len = p_of(act_c) + (mod_ext ? 1 : 0);
            end
            tick_prev = pre_out; fp_prev = fp;
            if (cfg_wr && exp_q.size() > 0) begin pend_c = exp_q.pop_front(); pend_v = 1; end
        end
    end

    initial begin
        int n;
        repeat (5) @(negedge clk);
        check(!fp && !pre_out && !mod_ext, "R1 reset outputs", {fp, pre_out, mod_ext}, 0);
        rst_n = 1'b1;
        n = 0;
        forever begin
            @(posedge clk); #1; n++;
            if (fp) break;
        end
        check(n == 320, "R1 first period", n, 320);

        // R8: mid-period write, applies at next boundary
        repeat (50) @(negedge clk);
        write_cfg(3, 7, 1'b0);
        wait_fp(3);

        // R8: write sampled on the boundary edge itself
        repeat (128 * 7 + 3 - 1) @(posedge clk);
        write_cfg(2, 9, 1'b1);
        wait_fp(3);

        // R10: A = 0 and A = N-1, and the smallest N
        write_cfg(0, 6, 1'b1);
        wait_fp(3);
        write_cfg(11, 12, 1'b0);
        wait_fp(3);
        write_cfg(4, 5, 1'b1);
        wait_fp(3);

        // R9: standby with a write inside it
        repeat (100) @(negedge clk);
        standby = 1'b1;
        repeat (5) @(negedge clk);
        write_cfg(5, 8, 1'b1);
        repeat (10) @(negedge clk);
        standby = 1'b0;
        wait_fp(2);

        // R2 R3: random legal settings
        for (int i = 0; i < 8; i++) begin
            int rn, ra;
            rn = 5 + int'($urandom % 20);
            ra = int'($urandom % rn);
            write_cfg(ra, rn, 1'($urandom % 2));
            wait_fp(3);
        end

        done = 1;
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        #(200000 * 8);
        if (!done) begin
            total++; fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end
endmodule